// File: doc/BRIEF.md
# NAND Controller Event Status and Interrupt Unit

This unit keeps the event flags of a NAND flash controller and folds them into one interrupt request line. Four sources feed it: an illegal-access pulse, the ready/busy pin of the flash device, an ECC-encode-complete pulse and an ECC-decode-complete pulse. Each source sets a sticky flag. Software clears a flag by writing a 1 to its bit in the status register. A control register holds one enable bit per source. Only enabled flags drive the interrupt and the encoded cause.

The ready/busy pin is asynchronous to the controller clock. It passes through a two-stage synchronizer, and only its low-to-high (busy-to-ready) transition sets the flag. The interrupt handler reads a two-bit cause code and a valid bit. These select the highest-priority pending source that is enabled, so the handler can service one source at a time.

Register access is a single-cycle write strobe with a one-bit register select, and the read data follows the select combinationally. The asynchronous active-low reset asserts at once and releases through a two-stage synchronizer.

Top module: `nand_evt_irq`

## Requirements
- R1: A high `ev_illegal` at a rising clock edge sets status bit 5, which stays set until cleared.
- R2: Status bit 4 is set on the third rising edge after `rb_async` goes from low to high and is held high. A high-to-low change of `rb_async` never sets it.
- R3: A high `ev_enc_done` sets status bit 7, and a high `ev_dec_done` sets status bit 6. Both flags are sticky.
- R4: A write to the status register (`reg_addr`=0) clears each of bits 4 to 7 whose write-data bit is 1. Write-data bits that are 0, and all other bit positions, leave the flags unchanged. Status bits other than 4 to 7 read as 0.
- R5: If a source's event and a write-1 clear of its flag arrive in the same cycle, the flag stays set.
- R6: The control register (`reg_addr`=1) holds the enables: bit 9 for ready/busy, bit 10 for illegal access, bit 11 for encode done and bit 12 for decode done. A write stores exactly these bits, and all other control bits read as 0.
- R7: `irq` is high in any cycle in which at least one flag and its enable are both set. It is low otherwise, and a flag that is set but not enabled does not raise it.
- R8: `cause_vld` equals `irq`. `cause` names the enabled pending source of highest priority, with the codes 0 = illegal access, 1 = ready/busy, 2 = encode done, 3 = decode done, in that order of priority. `cause` is 0 when nothing enabled is pending.
- R9: A low `rst_n` clears all flags and all enables at once. The unit then reads all zeros with `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 1 | Register select: 0 status, 1 control |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data of the selected register |
| ev_illegal | input | 1 | Illegal-access event |
| ev_enc_done | input | 1 | ECC encode-complete event |
| ev_dec_done | input | 1 | ECC decode-complete event |
| rb_async | input | 1 | Asynchronous ready/busy pin, high = ready |
| irq | output | 1 | Interrupt request |
| cause_vld | output | 1 | Encoded cause is valid |
| cause | output | 2 | Highest-priority enabled pending source |

## Verification
Direct events and register writes take effect at the first rising edge at which they are sampled. The flags, `irq`, the cause and the read data all change at that edge, so the bench drives each vector at a falling edge and checks one falling edge later. The ready/busy flag is due at the third rising edge after the pin rises. The bench checks it as clear after the second edge and as set after the third. A reset check is made half a cycle after `rst_n` falls, with no clock edge in between, because the reset acts asynchronously.

// File: rtl/nand_evt_pkg.sv
package nand_evt_pkg;
  // Event index order is also the service priority (index 0 wins).
  localparam int NEV = 4;
  localparam int IDX_ILL = 0;
  localparam int IDX_RB  = 1;
  localparam int IDX_ENC = 2;
  localparam int IDX_DEC = 3;
  localparam int CODE_W  = $clog2(NEV);

  typedef logic [CODE_W-1:0] cause_t;

  // Status word bit that holds the flag of event i.
  function automatic int stat_pos(input int i);
    case (i)
      IDX_ILL: stat_pos = 5;
      IDX_RB:  stat_pos = 4;
      IDX_ENC: stat_pos = 7;
      default: stat_pos = 6;
    endcase
  endfunction

  // Control word bit that enables event i.
  function automatic int en_pos(input int i);
    case (i)
      IDX_ILL: en_pos = 10;
      IDX_RB:  en_pos = 9;
      IDX_ENC: en_pos = 11;
      default: en_pos = 12;
    endcase
  endfunction
endpackage

// File: rtl/nevt_rst_sync.sv
module nevt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/nevt_rb_edge.sv
module nevt_rb_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_async,
  output logic rise
);
  // Reset to "ready" so a pin already high at reset gives no edge.
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;
  logic              last_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], rb_async};
    last_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/nevt_flag.sv
module nevt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic d;

  // Set beats clear.
  always_comb begin
    d = set | (q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d;
  end
endmodule

// File: rtl/nevt_prio.sv
module nevt_prio #(
  parameter int N  = 4,
  parameter int CW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          vld,
  output logic [CW-1:0] code
);
  always_comb begin
    vld  = 1'b0;
    code = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        vld  = 1'b1;
        code = CW'(i);
      end
    end
  end
endmodule

// File: rtl/nand_evt_irq.sv
module nand_evt_irq
  import nand_evt_pkg::*;
#(
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          ev_illegal,
  input  logic          ev_enc_done,
  input  logic          ev_dec_done,
  input  logic          rb_async,
  output logic          irq,
  output logic          cause_vld,
  output logic [1:0]    cause
);
  logic           core_rst_n;
  logic           rb_rise;
  logic           wr_stat;
  logic           wr_ctrl;
  logic [NEV-1:0] ev_vec;
  logic [NEV-1:0] clr_vec;
  logic [NEV-1:0] flag_q;
  logic [NEV-1:0] en_q;
  logic [NEV-1:0] en_d;
  logic [NEV-1:0] pend;
  cause_t         code;

  nevt_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (core_rst_n)
  );

  nevt_rb_edge #(.STAGES(SYNC_STAGES)) u_rb (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .rb_async (rb_async),
    .rise     (rb_rise)
  );

  assign wr_stat = reg_wr & ~reg_addr;
  assign wr_ctrl = reg_wr &  reg_addr;

  always_comb begin
    ev_vec          = '0;
    ev_vec[IDX_ILL] = ev_illegal;
    ev_vec[IDX_RB]  = rb_rise;
    ev_vec[IDX_ENC] = ev_enc_done;
    ev_vec[IDX_DEC] = ev_dec_done;
  end

  for (genvar i = 0; i < NEV; i++) begin : g_flag
    assign clr_vec[i] = wr_stat & reg_wdata[stat_pos(i)];
    nevt_flag u_flag (
      .clk   (clk),
      .rst_n (core_rst_n),
      .set   (ev_vec[i]),
      .clr   (clr_vec[i]),
      .q     (flag_q[i])
    );
  end

  // Enable register with explicit clock enable.
  always_comb begin
    en_d = en_q;
    if (wr_ctrl) begin
      for (int i = 0; i < NEV; i++) en_d[i] = reg_wdata[en_pos(i)];
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) en_q <= '0;
    else             en_q <= en_d;
  end

  assign pend = flag_q & en_q;
  assign irq  = |pend;

  nevt_prio #(.N(NEV), .CW(CODE_W)) u_prio (
    .req  (pend),
    .vld  (cause_vld),
    .code (code)
  );
  assign cause = code;

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NEV; i++) begin
      if (reg_addr) reg_rdata[en_pos(i)]   = en_q[i];
      else          reg_rdata[stat_pos(i)] = flag_q[i];
    end
  end
endmodule

// File: rtl/nand_evt_irq_chk.sv
module nand_evt_irq_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          core_rst_n,
  input logic          reg_wr,
  input logic          reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic          ev_illegal,
  input logic          rb_async,
  input logic [3:0]    flag_q,
  input logic [3:0]    en_q,
  input logic          irq,
  input logic          cause_vld,
  input logic [1:0]    cause
);
  // R1
  ill_sets_flag_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    ev_illegal |=> flag_q[0]);

  // R2
  rb_flag_needs_high_pin_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(flag_q[1]) |-> $past(rb_async));

  // R4
  ill_flag_sticky_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (flag_q[0] && !(reg_wr && !reg_addr && reg_wdata[5])) |=> flag_q[0]);

  // R4
  enc_flag_sticky_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (flag_q[2] && !(reg_wr && !reg_addr && reg_wdata[7])) |=> flag_q[2]);

  // R8
  cause_tracks_irq_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    cause_vld == irq);

  // R8
  ill_top_priority_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (flag_q[0] && en_q[0]) |-> (cause == 2'd0));

  // R7
  no_irq_when_disabled_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (en_q == 4'd0) |-> !irq);
endmodule

bind nand_evt_irq nand_evt_irq_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .core_rst_n (core_rst_n),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .ev_illegal (ev_illegal),
  .rb_async   (rb_async),
  .flag_q     (flag_q),
  .en_q       (en_q),
  .irq        (irq),
  .cause_vld  (cause_vld),
  .cause      (cause)
);

// File: tb/test_nand_evt_irq.sv
module test_nand_evt_irq;
  localparam int DW = 16;

  typedef struct packed {
    logic        wr;
    logic        addr;
    logic [15:0] wd;
    logic        ill;
    logic        enc;
    logic        dec;
    logic [7:0]  st;
    logic        irq;
    logic        vld;
    logic [1:0]  cause;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b1, 16'h1E00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 2'd0}, // R6 all on
    '{1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 8'h40, 1'b1, 1'b1, 2'd3}, // R3 dec
    '{1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 8'hC0, 1'b1, 1'b1, 2'd2}, // R3 enc
    '{1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 8'hE0, 1'b1, 1'b1, 2'd0}, // R1 ill
    '{1'b1, 1'b0, 16'h0020, 1'b0, 1'b0, 1'b0, 8'hC0, 1'b1, 1'b1, 2'd2}, // R4 clr ill
    '{1'b1, 1'b1, 16'h1600, 1'b0, 1'b0, 1'b0, 8'hC0, 1'b1, 1'b1, 2'd3}, // R7 enc off
    '{1'b1, 1'b0, 16'h0040, 1'b0, 1'b0, 1'b0, 8'h80, 1'b0, 1'b0, 2'd0}, // R7 masked
    '{1'b1, 1'b1, 16'h1E00, 1'b0, 1'b0, 1'b0, 8'h80, 1'b1, 1'b1, 2'd2}, // R6 re-enable
    '{1'b1, 1'b0, 16'hFF0F, 1'b0, 1'b0, 1'b0, 8'h80, 1'b1, 1'b1, 2'd2}, // R4 other bits
    '{1'b1, 1'b0, 16'h0080, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 2'd0}, // R4 clr enc
    '{1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 8'h20, 1'b1, 1'b1, 2'd0}, // R1 again
    '{1'b1, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 8'h20, 1'b0, 1'b0, 2'd0}, // R7 all off
    '{1'b1, 1'b0, 16'h00FF, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 2'd0}  // R4 clr all
  };

  logic          clk;
  logic          rst_n;
  logic          reg_wr;
  logic          reg_addr;
  logic [DW-1:0] reg_wdata;
  logic [DW-1:0] reg_rdata;
  logic          ev_illegal;
  logic          ev_enc_done;
  logic          ev_dec_done;
  logic          rb_async;
  logic          irq;
  logic          cause_vld;
  logic [1:0]    cause;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  nand_evt_irq #(.DW(DW)) i_nand_evt_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .ev_illegal  (ev_illegal),
    .ev_enc_done (ev_enc_done),
    .ev_dec_done (ev_dec_done),
    .rb_async    (rb_async),
    .irq         (irq),
    .cause_vld   (cause_vld),
    .cause       (cause)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    reg_wr      = 1'b0;
    reg_addr    = 1'b0;
    reg_wdata   = '0;
    ev_illegal  = 1'b0;
    ev_enc_done = 1'b0;
    ev_dec_done = 1'b0;
  endtask

  // Outputs sampled one falling edge after the driving rising edge.
  task automatic check_out(input string req, input logic [7:0] st, input logic ei,
                           input logic ev, input logic [1:0] ec);
    reg_addr = 1'b0;
    #1;
    chk({req, " status"}, 32'(reg_rdata), {24'h0, st});
    chk({req, " irq"}, 32'(irq), 32'(ei));
    chk({req, " cause_vld"}, 32'(cause_vld), 32'(ev));
    chk({req, " cause"}, 32'(cause), 32'(ec));
  endtask

  task automatic wr_reg(input logic a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    rb_async = 1'b1;
    rst_n    = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);

    // R9 reset state
    check_out("R9 reset", 8'h00, 1'b0, 1'b0, 2'd0);
    reg_addr = 1'b1; #1;
    chk("R9 ctrl reset", 32'(reg_rdata), 32'h0);
    reg_addr = 1'b0;

    // Vector table
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      reg_wr      = VEC[k].wr;
      reg_addr    = VEC[k].addr;
      reg_wdata   = VEC[k].wd;
      ev_illegal  = VEC[k].ill;
      ev_enc_done = VEC[k].enc;
      ev_dec_done = VEC[k].dec;
      @(posedge clk);
      @(negedge clk);
      idle();
      check_out($sformatf("R3/R4/R7/R8 vec%0d", k), VEC[k].st, VEC[k].irq, VEC[k].vld, VEC[k].cause);
    end

    // R2 ready/busy edge timing
    wr_reg(1'b1, 16'h1E00);
    @(negedge clk); rb_async = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check_out("R2 falling edge ignored", 8'h00, 1'b0, 1'b0, 2'd0);
    rb_async = 1'b1;
    @(posedge clk); @(negedge clk);
    check_out("R2 after edge 1", 8'h00, 1'b0, 1'b0, 2'd0);
    @(posedge clk); @(negedge clk);
    check_out("R2 after edge 2", 8'h00, 1'b0, 1'b0, 2'd0);
    @(posedge clk); @(negedge clk);
    check_out("R2 after edge 3", 8'h10, 1'b1, 1'b1, 2'd1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_out("R2 held high no re-trigger keeps flag", 8'h10, 1'b1, 1'b1, 2'd1);

    // R8 illegal outranks ready/busy
    ev_illegal = 1'b1;
    @(posedge clk); @(negedge clk);
    idle();
    check_out("R8 ill over rb", 8'h30, 1'b1, 1'b1, 2'd0);

    // R5 event and clear in the same cycle
    reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 16'h0030; ev_illegal = 1'b1;
    @(posedge clk); @(negedge clk);
    idle();
    check_out("R5 set wins over clear", 8'h20, 1'b1, 1'b1, 2'd0);

    // R6 only enable bits are stored
    wr_reg(1'b1, 16'hFFFF);
    reg_addr = 1'b1; #1;
    chk("R6 ctrl readback", 32'(reg_rdata), 32'h1E00);
    reg_addr = 1'b0;

    // R9 asynchronous reset with state present
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_out("R9 async clear", 8'h00, 1'b0, 1'b0, 2'd0);
    reg_addr = 1'b1; #1;
    chk("R9 ctrl cleared", 32'(reg_rdata), 32'h0);
    reg_addr = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule